// File: doc/BRIEF.md
# Bus hold-acknowledge release controller

This block sits on the owning side of a shared expansion bus. An outside requester asks for the bus by raising a hold request. The controller stops granting new local transactions and waits until a minimum latency has passed and any transfer already under way has finished. It then turns off its bus drivers and, one clock later, raises hold-acknowledge. When the requester withdraws its request, the controller waits the same minimum latency, drops acknowledge, and one clock later drives the bus again. The bus group that is released is the byte-enable/address lines, the address strobe, the read/write line and the burst-last line. The pad buffers themselves are outside this block; it only supplies their enable.

The hold request is brought into the clock domain through a two-stage synchronizer. A small down-counter times the minimum latency from the synchronized edge. A five-state machine orders the sequence. In OWN the block drives the bus and passes local requests through. DRAIN is entered when the synchronized request is seen in OWN. DRAIN moves to RELEASE once the latency count has run out and the engine is idle or on its last beat. RELEASE always moves to HELD after one clock. HELD reloads the count while the request stays high, and moves to RECLAIM once the request has been low for the whole count. RECLAIM always moves back to OWN after one clock. A request that drops part-way through the sequence is not honoured early: the sequence runs through HELD and then reclaims the bus.

Top module: `bus_yield_ctrl`

## Requirements
- R1: After reset, `drv_en_o` is 1, `hold_ack_o` is 0 and `loc_grant_o` follows `loc_req_i`.
- R2: `drv_en_o` never falls sooner than MIN_LAT (4) clocks after the synchronized request rises. With an idle engine it falls on the 7th rising edge, counting as the first the edge that first samples `hold_req_i` high.
- R3: `hold_ack_o` rises exactly one clock after `drv_en_o` falls.
- R4: Before release the engine is drained. The bus stays driven while `eng_busy_i`=1 and `eng_last_i`=0. It is released on the later of the R2 edge and the edge that samples `eng_busy_i`=0 or `eng_last_i`=1.
- R5: `hold_ack_o` never falls sooner than MIN_LAT clocks after the synchronized request falls.
- R6: `drv_en_o` rises exactly one clock after `hold_ack_o` falls.
- R7: `loc_grant_o` equals `loc_req_i` only in OWN. It is 0 from the entry into DRAIN until the return to OWN.
- R8: `hold_ack_o` and `drv_en_o` are never both 1.
- R9: If the request is withdrawn after the sequence has started, the bus is still handed over (`hold_ack_o` rises) and is then reclaimed.
- R10: If the request rises again during the HELD wait, `hold_ack_o` stays high and the MIN_LAT count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_req_i | input | 1 | Hold request from the outside requester (synchronized inside) |
| eng_busy_i | input | 1 | Local transaction engine has a transfer in flight |
| eng_last_i | input | 1 | Current beat is the last beat of the transfer |
| loc_req_i | input | 1 | Local request to start a transaction |
| hold_ack_o | output | 1 | Hold acknowledge to the requester |
| drv_en_o | output | 1 | Output enable for the released bus drivers |
| loc_grant_o | output | 1 | Local request let through (blocked while yielding) |

## Verification
If the state machine is in the wrong state, the ports show it within one clock. An early exit from DRAIN makes `drv_en_o` fall before the MIN_LAT edge or while a transfer is still mid-burst. A skipped RELEASE or RECLAIM makes acknowledge and driver enable change on the same edge, or overlap. A stale counter shows up as a release or reclaim edge that comes too soon after the request toggles. Directed scenarios measure these edge distances in clocks. They also run transactions of random length against the drain rule and observe the local grant throughout the yield.

// File: rtl/yield_pkg.sv
package yield_pkg;

    typedef enum logic [2:0] {
        Y_OWN     = 3'd0,
        Y_DRAIN   = 3'd1,
        Y_RELEASE = 3'd2,
        Y_HELD    = 3'd3,
        Y_RECLAIM = 3'd4
    } yield_state_e;

endpackage

// File: rtl/yield_sync.sv
module yield_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/yield_timer.sv
module yield_timer #(
    parameter int MIN_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic zero_o
);

    localparam int CW = (MIN_LAT < 2) ? 1 : $clog2(MIN_LAT);
    localparam logic [CW-1:0] RELOAD = CW'(MIN_LAT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= RELOAD;
        else if (load_i)     cnt <= RELOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= RELOAD); // R2

    AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !zero_o || (RELOAD == '0)); // R5

endmodule

// File: rtl/yield_fsm.sv
module yield_fsm
    import yield_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_sync_i,
    input  logic lat_zero_i,
    input  logic eng_busy_i,
    input  logic eng_last_i,
    output logic timer_load_o,
    output logic drv_en_o,
    output logic hold_ack_o,
    output logic own_o
);

    yield_state_e state, nxt;
    logic         drain_ok;

    assign drain_ok = !eng_busy_i || eng_last_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Y_OWN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            Y_OWN:     if (hold_sync_i)                 nxt = Y_DRAIN;
            Y_DRAIN:   if (lat_zero_i && drain_ok)      nxt = Y_RELEASE;
            Y_RELEASE:                                  nxt = Y_HELD;
            Y_HELD:    if (!hold_sync_i && lat_zero_i)  nxt = Y_RECLAIM;
            Y_RECLAIM:                                  nxt = Y_OWN;
            default:                                    nxt = Y_OWN;
        endcase
    end

    always_comb begin
        drv_en_o     = 1'b0;
        hold_ack_o   = 1'b0;
        own_o        = 1'b0;
        timer_load_o = 1'b0;
        unique case (state)
            Y_OWN: begin
                drv_en_o     = 1'b1;
                own_o        = 1'b1;
                timer_load_o = 1'b1;
            end
            Y_DRAIN: begin
                drv_en_o     = 1'b1;
            end
            Y_RELEASE: begin
                timer_load_o = 1'b1;
            end
            Y_HELD: begin
                hold_ack_o   = 1'b1;
                timer_load_o = hold_sync_i;
            end
            Y_RECLAIM: begin
            end
            default: begin
            end
        endcase
    end

    AST_ACK_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en_o) |=> $rose(hold_ack_o)); // R3

    AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en_o) |-> $past(!eng_busy_i || eng_last_i)); // R4

    AST_DRIVE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_o) |=> $rose(drv_en_o)); // R6

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_ack_o && drv_en_o)); // R8

    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack_o && hold_sync_i) |=> hold_ack_o); // R10

endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl #(
    parameter int MIN_LAT     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_i,
    input  logic eng_busy_i,
    input  logic eng_last_i,
    input  logic loc_req_i,
    output logic hold_ack_o,
    output logic drv_en_o,
    output logic loc_grant_o
);

    localparam int SW = $clog2(MIN_LAT + 1);
    localparam logic [SW-1:0] SAT = SW'(MIN_LAT);

    logic hold_sync;
    logic lat_zero;
    logic timer_load;
    logic own;

    yield_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (hold_req_i),
        .q_o   (hold_sync)
    );

    yield_timer #(.MIN_LAT(MIN_LAT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (timer_load),
        .zero_o (lat_zero)
    );

    yield_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_sync_i  (hold_sync),
        .lat_zero_i   (lat_zero),
        .eng_busy_i   (eng_busy_i),
        .eng_last_i   (eng_last_i),
        .timer_load_o (timer_load),
        .drv_en_o     (drv_en_o),
        .hold_ack_o   (hold_ack_o),
        .own_o        (own)
    );

    assign loc_grant_o = loc_req_i && own;

    // Edge-age trackers for the latency checks
    logic          sync_d;
    logic [SW-1:0] since_rise;
    logic [SW-1:0] since_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_d     <= 1'b0;
            since_rise <= SAT;
            since_fall <= SAT;
        end else begin
            sync_d <= hold_sync;
            if (hold_sync && !sync_d)    since_rise <= SW'(1);
            else if (since_rise != SAT)  since_rise <= since_rise + 1'b1;
            if (!hold_sync && sync_d)    since_fall <= SW'(1);
            else if (since_fall != SAT)  since_fall <= since_fall + 1'b1;
        end
    end

    AST_MIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en_o) |-> since_rise == SAT); // R2

    AST_MIN_RECLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_o) |-> since_fall == SAT); // R5

    AST_GRANT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack_o || !drv_en_o) |-> !loc_grant_o); // R7

    AST_RESET_DRIVE: assert property (@(posedge clk)
        !rst_n |-> (drv_en_o && !hold_ack_o)); // R1

endmodule

// File: tb/sim_bus_yield_ctrl.sv
module sim_bus_yield_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req = 1'b0;
    logic busy = 1'b0;
    logic last = 1'b0;
    logic loc_req = 1'b0;
    logic ack, drv_en, grant;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_yield_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_req_i  (hold_req),
        .eng_busy_i  (busy),
        .eng_last_i  (last),
        .loc_req_i   (loc_req),
        .hold_ack_o  (ack),
        .drv_en_o    (drv_en),
        .loc_grant_o (grant)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling edges until drv_en drops (limit 40)
    task automatic wait_release(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (drv_en && n < 40);
    endtask

    task automatic t_reset;
        loc_req = 1'b1;
        @(negedge clk);
        chk(drv_en == 1'b1, "R1 drv_en", drv_en, 1);
        chk(ack == 1'b0, "R1 ack", ack, 0);
        chk(grant == 1'b1, "R1/R7 grant in OWN", grant, 1);
    endtask

    task automatic t_grab_idle;
        int n;
        int m;
        bit grant_seen;
        n = 0;
        grant_seen = 1'b0;
        hold_req = 1'b1;
        loc_req = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (n >= 3 && grant) grant_seen = 1'b1;
            chk(!(ack && drv_en), "R8 overlap", int'(ack && drv_en), 0);
        end while (drv_en && n < 40);
        chk(n >= 4, "R2 min release latency", n, 4);
        chk(n == 7, "R2 idle release edge", n, 7);
        chk(!grant_seen, "R7 grant blocked in DRAIN", int'(grant_seen), 0);
        m = 0;
        do begin
            @(negedge clk);
            m++;
        end while (!ack && m < 10);
        chk(m == 1, "R3 ack one clock after float", m, 1);
        chk(grant == 1'b0, "R7 grant blocked in HELD", grant, 0);
    endtask

    task automatic t_free;
        int n;
        int m;
        n = 0;
        hold_req = 1'b0;
        do begin
            @(negedge clk);
            n++;
            chk(!(ack && drv_en), "R8 overlap", int'(ack && drv_en), 0);
        end while (ack && n < 40);
        chk(n >= 4, "R5 min reclaim latency", n, 4);
        chk(n == 6, "R5 idle reclaim edge", n, 6);
        chk(drv_en == 1'b0, "R6 drivers still off when ack drops", drv_en, 0);
        m = 0;
        do begin
            @(negedge clk);
            m++;
        end while (!drv_en && m < 10);
        chk(m == 1, "R6 drive one clock after ack", m, 1);
        loc_req = 1'b1;
        #1;
        chk(grant == 1'b1, "R7 grant back in OWN", grant, 1);
    endtask

    task automatic t_drain_hold;
        busy = 1'b1;
        last = 1'b0;
        hold_req = 1'b1;
        repeat (12) @(negedge clk);
        chk(drv_en == 1'b1, "R4 held while busy", drv_en, 1);
        chk(ack == 1'b0, "R4 no ack while busy", ack, 0);
        last = 1'b1;
        @(negedge clk);
        chk(drv_en == 1'b0, "R4 release after last beat", drv_en, 0);
        busy = 1'b0;
        last = 1'b0;
        @(negedge clk);
        chk(ack == 1'b1, "R3 ack after drained release", ack, 1);
        t_free();
    endtask

    task automatic t_drain_random;
        for (int it = 0; it < 4; it++) begin
            int len;
            int n;
            int exp;
            len = $urandom_range(6, 15);
            exp = (len > 7) ? len : 7;
            n = 0;
            busy = 1'b1;
            last = 1'b0;
            hold_req = 1'b1;
            do begin
                @(negedge clk);
                n++;
                if (!drv_en) break;
                if (n == len - 1) last = 1'b1;
                if (n == len) begin
                    busy = 1'b0;
                    last = 1'b0;
                end
            end while (n < 40);
            busy = 1'b0;
            last = 1'b0;
            chk(n == exp, "R4 drain release edge", n, exp);
            @(negedge clk);
            t_free();
        end
    endtask

    task automatic t_early_drop;
        bit saw_ack;
        saw_ack = 1'b0;
        hold_req = 1'b1;
        repeat (2) @(negedge clk);
        hold_req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ack) saw_ack = 1'b1;
        end
        chk(saw_ack, "R9 handover completes", int'(saw_ack), 1);
        chk(drv_en == 1'b1 && ack == 1'b0, "R9 bus reclaimed", int'(drv_en), 1);
    endtask

    task automatic t_rearm;
        int drops;
        drops = 0;
        t_grab_idle();
        hold_req = 1'b0;
        repeat (2) @(negedge clk);
        hold_req = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!ack) drops++;
        end
        chk(drops == 0, "R10 ack kept on re-request", drops, 0);
        t_free();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_grab_idle();
        t_free();
        t_drain_hold();
        t_drain_random();
        t_early_drop();
        t_rearm();
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule